// File: doc/BRIEF.md
# Indirect Register Access Window

This block gives a bus master access to a bank of configuration registers through two locations only. One is an index register and the other is a data window. The master first writes an index to the index register. It then reads or writes the chosen 32-bit register through the window. The registers that can be chosen are an identification word, a fixed revision word, and a table of 64-bit routing entries. Each routing entry is reached as two separate 32-bit halves.

The bus is a plain strobe interface. A read or write takes effect on the clock edge where its enable is high. Read data comes back one cycle later together with a valid flag. Each write that lands in a routing entry produces a one-cycle update pulse one cycle later. The pulse carries the entry number and the full 64-bit value the entry now holds, so that downstream storage or delivery logic can follow the change.

Top module: `indirect_reg_window`

## Requirements
- R1: The index register is 8 bits wide and sits at byte offset 0x00. Writing it stores bits 7:0 of the write data, and reading it returns that value zero-extended. Only the low 8 address bits are decoded, so bits above them have no effect.
- R2: A read with busRdEn high returns busRdData with busRdValid high on the next cycle. Any address whose low byte is neither 0x00 nor 0x10 (the window) reads as zero, and writes to it change nothing.
- R3: Window index 0 is the identification word. A write stores bits 27:24 of the write data, and a read returns them at bits 27:24 with every other bit zero.
- R4: Window index 1 is the revision word. It always reads 0x00170011: bits 7:0 hold the code 0x11 and bits 23:16 hold the entry count minus one (23). Writes to it have no effect.
- R5: Window indices from 0x10 upward select routing entry (index - 0x10) >> 1. An even index selects bits 31:0 of that entry and an odd index selects bits 63:32.
- R6: A write through the window to one half of an entry replaces that half only. The other 32 bits keep their value.
- R7: Window indices 2 to 0x0F, and indices at or above 0x40 (beyond entry 23), read as zero. Writes to them are ignored and raise no update pulse.
- R8: A write that lands in an entry drives updValid high for exactly the next cycle. During that cycle updEntry holds the entry number and updData holds the new 64-bit entry value. No other write raises updValid.
- R9: Reset clears the index register, the identification field and every routing entry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Bus byte address; only the low 8 bits are decoded |
| busWrEn | input | 1 | Write strobe, one cycle |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe, one cycle |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| busRdValid | output | 1 | High for the cycle that carries read data |
| updValid | output | 1 | One-cycle pulse after an entry write |
| updEntry | output | 5 | Number of the entry that was written |
| updData | output | 64 | Full value of that entry after the write |

## Verification
The assertions assume busRdEn and busWrEn are held low while reset is active. They also assume busAddr is always a known value, because the properties compare the data seen on a read or an update pulse with the index register and address from the cycle before. The stimulus drives every input on the falling clock edge and keeps the strobes low throughout reset. Each bus access is issued as its own strobe, so the registered read data and update pulses can be matched one to one against the access that caused them.

// File: rtl/irw_pkg.sv
package irw_pkg;

  // Source selected for the registered read-data mux
  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_SEL,
    SRC_ID,
    SRC_VER,
    SRC_ENT
  } rdSrc_e;

  // Strobes from decode control to the storage datapath
  typedef struct packed {
    logic   idWr;
    logic   entWr;
    logic   entHi;
    logic   rdEn;
    rdSrc_e rdSrc;
  } ctrlStrobe_t;

endpackage

// File: rtl/irw_ctrl.sv
module irw_ctrl
  import irw_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SEL_W       = 8,
  parameter int NUM_ENTRIES = 24,
  parameter int REDIR_BASE  = 16,
  parameter int SEL_OFFSET  = 0,
  parameter int WIN_OFFSET  = 16,
  parameter int ENT_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [SEL_W-1:0]  selWrData,
  output ctrlStrobe_t       strobe,
  output logic [ENT_W-1:0]  entIdx,
  output logic [SEL_W-1:0]  selQ
);

  localparam int OFF_W = 8;

  logic [OFF_W-1:0] offset;
  logic             hitSel;
  logic             hitWin;
  logic             isId;
  logic             isVer;
  logic             aboveBase;
  logic [SEL_W-1:0] relIdx;
  logic [SEL_W-1:0] entWide;
  logic             entValid;

  assign offset = busAddr[OFF_W-1:0];
  assign hitSel = (offset == OFF_W'(SEL_OFFSET));
  assign hitWin = (offset == OFF_W'(WIN_OFFSET));

  generate
    if (ADDR_W > OFF_W) begin : g_upper
      logic unusedUpperAddr;
      assign unusedUpperAddr = ^busAddr[ADDR_W-1:OFF_W];
    end
  endgenerate

  // Index decode
  assign isId      = (selQ == SEL_W'(0));
  assign isVer     = (selQ == SEL_W'(1));
  assign aboveBase = (selQ >= SEL_W'(REDIR_BASE));
  assign relIdx    = selQ - SEL_W'(REDIR_BASE);
  assign entWide   = relIdx >> 1;
  assign entValid  = aboveBase && (entWide < SEL_W'(NUM_ENTRIES));
  assign entIdx    = entWide[ENT_W-1:0];

  always_comb begin
    strobe.idWr  = busWrEn && hitWin && isId;
    strobe.entWr = busWrEn && hitWin && entValid;
    strobe.entHi = relIdx[0];
    strobe.rdEn  = busRdEn;
    if (hitSel)
      strobe.rdSrc = SRC_SEL;
    else if (hitWin && isId)
      strobe.rdSrc = SRC_ID;
    else if (hitWin && isVer)
      strobe.rdSrc = SRC_VER;
    else if (hitWin && entValid)
      strobe.rdSrc = SRC_ENT;
    else
      strobe.rdSrc = SRC_ZERO;
  end

  // Index register
  always_ff @(posedge clk) begin
    if (!rstN)
      selQ <= '0;
    else if (busWrEn && hitSel)
      selQ <= selWrData;
  end

endmodule

// File: rtl/irw_datapath.sv
module irw_datapath
  import irw_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SEL_W        = 8,
  parameter int NUM_ENTRIES  = 24,
  parameter int ENT_W        = 5,
  parameter int ID_LSB       = 24,
  parameter int ID_W         = 4,
  parameter int VERSION_CODE = 17,
  parameter int MAXENT_LSB   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [ENT_W-1:0]    entIdx,
  input  logic [SEL_W-1:0]    selQ,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  output logic                updValid,
  output logic [ENT_W-1:0]    updEntry,
  output logic [2*DATA_W-1:0] updData
);

  localparam int ENTRY_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] VER_WORD =
    DATA_W'(VERSION_CODE) | (DATA_W'(NUM_ENTRIES - 1) << MAXENT_LSB);

  logic [ID_W-1:0]    idQ;
  logic [ENTRY_W-1:0] entQ [NUM_ENTRIES];
  logic [ENTRY_W-1:0] curEntry;
  logic [ENTRY_W-1:0] newEntry;
  logic [DATA_W-1:0]  rdMux;

  assign curEntry = (entIdx < ENT_W'(NUM_ENTRIES)) ? entQ[entIdx] : '0;

  // Merge the written half, keep the other one
  assign newEntry = strobe.entHi ? {wrData, curEntry[DATA_W-1:0]}
                                 : {curEntry[ENTRY_W-1:DATA_W], wrData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_ENTRIES; k++) entQ[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_ENTRIES; k++)
        if (strobe.entWr && entIdx == ENT_W'(k)) entQ[k] <= newEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      idQ <= '0;
    else if (strobe.idWr)
      idQ <= wrData[ID_LSB +: ID_W];
  end

  always_comb begin
    case (strobe.rdSrc)
      SRC_SEL: rdMux = DATA_W'(selQ);
      SRC_ID:  rdMux = DATA_W'(idQ) << ID_LSB;
      SRC_VER: rdMux = VER_WORD;
      SRC_ENT: rdMux = strobe.entHi ? curEntry[ENTRY_W-1:DATA_W]
                                    : curEntry[DATA_W-1:0];
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdData   <= '0;
      updValid <= 1'b0;
      updEntry <= '0;
      updData  <= '0;
    end else begin
      rdValid  <= strobe.rdEn;
      rdData   <= strobe.rdEn ? rdMux : '0;
      updValid <= strobe.entWr;
      updEntry <= strobe.entWr ? entIdx : '0;
      updData  <= strobe.entWr ? newEntry : '0;
    end
  end

endmodule

// File: rtl/indirect_reg_window.sv
module indirect_reg_window
  import irw_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  parameter int SEL_W        = 8,
  parameter int NUM_ENTRIES  = 24,
  parameter int REDIR_BASE   = 16,
  parameter int SEL_OFFSET   = 0,
  parameter int WIN_OFFSET   = 16,
  parameter int ID_LSB       = 24,
  parameter int ID_W         = 4,
  parameter int VERSION_CODE = 17,
  parameter int MAXENT_LSB   = 16,
  localparam int ENT_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic                busRdEn,
  output logic [DATA_W-1:0]   busRdData,
  output logic                busRdValid,
  output logic                updValid,
  output logic [ENT_W-1:0]    updEntry,
  output logic [2*DATA_W-1:0] updData
);

  ctrlStrobe_t      strobe;
  logic [ENT_W-1:0] entIdx;
  logic [SEL_W-1:0] selQ;

  irw_ctrl #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .NUM_ENTRIES(NUM_ENTRIES),
    .REDIR_BASE(REDIR_BASE), .SEL_OFFSET(SEL_OFFSET),
    .WIN_OFFSET(WIN_OFFSET), .ENT_W(ENT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .selWrData(busWrData[SEL_W-1:0]),
    .strobe(strobe), .entIdx(entIdx), .selQ(selQ)
  );

  irw_datapath #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_ENTRIES(NUM_ENTRIES),
    .ENT_W(ENT_W), .ID_LSB(ID_LSB), .ID_W(ID_W),
    .VERSION_CODE(VERSION_CODE), .MAXENT_LSB(MAXENT_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .entIdx(entIdx),
    .selQ(selQ), .wrData(busWrData), .rdData(busRdData),
    .rdValid(busRdValid), .updValid(updValid), .updEntry(updEntry),
    .updData(updData)
  );

endmodule

// File: rtl/irw_checker.sv
module irw_checker #(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  parameter int SEL_W        = 8,
  parameter int NUM_ENTRIES  = 24,
  parameter int REDIR_BASE   = 16,
  parameter int SEL_OFFSET   = 0,
  parameter int WIN_OFFSET   = 16,
  parameter int VERSION_CODE = 17,
  parameter int MAXENT_LSB   = 16,
  parameter int ENT_W        = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              busRdValid,
  input logic              updValid,
  input logic [ENT_W-1:0]  updEntry,
  input logic [SEL_W-1:0]  selQ
);

  localparam logic [DATA_W-1:0] VER_WORD =
    DATA_W'(VERSION_CODE) | (DATA_W'(NUM_ENTRIES - 1) << MAXENT_LSB);
  localparam int TOP_IDX = REDIR_BASE + 2 * NUM_ENTRIES;

  logic [7:0] offset;
  assign offset = busAddr[7:0];

  AST_RD_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    busRdValid == $past(busRdEn)); // R2

  AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busRdEn) && $past(offset) == 8'(SEL_OFFSET))
      |-> busRdData == DATA_W'($past(selQ))); // R1

  AST_VER_CONST: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busRdEn) && $past(offset) == 8'(WIN_OFFSET) && $past(selQ) == SEL_W'(1))
      |-> busRdData == VER_WORD); // R4

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busRdEn) && $past(offset) == 8'(WIN_OFFSET) &&
     32'($past(selQ)) >= 32'(TOP_IDX)) |-> busRdData == '0); // R7

  AST_UPD_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> ($past(busWrEn) && $past(offset) == 8'(WIN_OFFSET) &&
                  32'($past(selQ)) >= 32'(REDIR_BASE) &&
                  32'($past(selQ)) < 32'(TOP_IDX))); // R8

  AST_UPD_ENTRY_MAP: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> 32'(updEntry) == ((32'($past(selQ)) - 32'(REDIR_BASE)) >> 1)); // R5

  AST_UPD_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> 32'(updEntry) < 32'(NUM_ENTRIES)); // R7

endmodule

bind indirect_reg_window irw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
  .NUM_ENTRIES(NUM_ENTRIES), .REDIR_BASE(REDIR_BASE),
  .SEL_OFFSET(SEL_OFFSET), .WIN_OFFSET(WIN_OFFSET),
  .VERSION_CODE(VERSION_CODE), .MAXENT_LSB(MAXENT_LSB), .ENT_W(ENT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busRdData(busRdData), .busRdValid(busRdValid),
  .updValid(updValid), .updEntry(updEntry), .selQ(selQ)
);

// File: tb/indirect_reg_window_tb.sv
module indirect_reg_window_tb;

  localparam int NE   = 24;
  localparam int BASE = 16;
  localparam int TOP  = BASE + 2 * NE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic        updValid;
  logic [4:0]  updEntry;
  logic [63:0] updData;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [63:0] entM [NE];
  logic [3:0]  idM = '0;
  logic [7:0]  selM = '0;

  always #5 clk = ~clk;

  indirect_reg_window u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .busRdValid(busRdValid), .updValid(updValid), .updEntry(updEntry),
    .updData(updData)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    chk(busRdValid == 1'b1, "R2 read valid", 64'(busRdValid), 64'd1);
    d = busRdData;
  endtask

  function automatic logic [31:0] expWin(input int idx);
    if (idx == 0) return {4'h0, idM, 24'h0};
    if (idx == 1) return 32'h0017_0011;
    if (idx >= BASE && idx < TOP)
      return ((idx - BASE) % 2 == 1) ? entM[(idx - BASE) / 2][63:32]
                                     : entM[(idx - BASE) / 2][31:0];
    return 32'h0;
  endfunction

  function automatic string reqFor(input int idx);
    if (idx == 0) return "R3 id word";
    if (idx == 1) return "R4 revision word";
    if (idx >= BASE && idx < TOP) return "R5 entry half";
    return "R7 unmapped index";
  endfunction

  // Write through the window at index idx and check the update pulse
  task automatic winWrite(input int idx, input logic [31:0] d);
    int e;
    wr(12'h000, 32'(idx));
    selM = 8'(idx);
    wr(12'h010, d);
    if (idx == 0) idM = d[27:24];
    if (idx >= BASE && idx < TOP) begin
      e = (idx - BASE) / 2;
      if ((idx - BASE) % 2 == 1) entM[e][63:32] = d;
      else entM[e][31:0] = d;
      chk(updValid == 1'b1, "R8 pulse raised", 64'(updValid), 64'd1);
      chk(updEntry == 5'(e), "R8 entry number", 64'(updEntry), 64'(e));
      chk(updData == entM[e], "R6 merged entry", updData, entM[e]);
      @(negedge clk);
      chk(updValid == 1'b0, "R8 pulse one cycle", 64'(updValid), 64'd0);
    end else begin
      chk(updValid == 1'b0, "R7 no pulse", 64'(updValid), 64'd0);
    end
  endtask

  task automatic winReadCheck(input int idx);
    logic [31:0] d;
    wr(12'h000, 32'(idx));
    selM = 8'(idx);
    rd(12'h010, d);
    chk(d == expWin(idx), reqFor(idx), 64'(d), 64'(expWin(idx)));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    for (int k = 0; k < NE; k++) entM[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    rd(12'h000, d);
    chk(d == 32'h0, "R9 index reset", 64'(d), 64'h0);
    for (int i = 0; i < TOP; i++) winReadCheck(i);

    // R1: index register readback across all values, upper address bits set
    for (int v = 0; v < 256; v++) begin
      wr(12'hA00, 32'hFFFF_FF00 | 32'(v));
      rd(12'h500, d);
      chk(d == 32'(v), "R1 index readback", 64'(d), 64'(v));
    end

    // R3: only the id field is kept
    winWrite(0, 32'hFFFF_FFFF);
    winReadCheck(0);
    winWrite(0, 32'h5A00_0000);
    winReadCheck(0);

    // R4: revision write ignored
    winWrite(1, 32'hDEAD_BEEF);
    winReadCheck(1);

    // Sweep all indices with writes, then read them all back (R5, R6, R7)
    for (int i = 2; i < 256; i++)
      winWrite(i, 32'h9E37_79B9 * 32'(i + 1));
    for (int i = 0; i < 256; i++) winReadCheck(i);

    // R6: rewrite only upper halves, lower halves must survive
    for (int i = BASE + 1; i < TOP; i += 2)
      winWrite(i, ~(32'h1234_5678 * 32'(i)));
    for (int i = BASE; i < TOP; i++) winReadCheck(i);

    // R2: undecoded offsets read zero and writes change nothing
    wr(12'h000, 32'(BASE + 4));
    selM = 8'(BASE + 4);
    wr(12'h004, 32'hFFFF_FFFF);
    chk(updValid == 1'b0, "R2 undecoded write no pulse", 64'(updValid), 64'd0);
    wr(12'h011, 32'h0000_0000);
    rd(12'h004, d);
    chk(d == 32'h0, "R2 undecoded read zero", 64'(d), 64'h0);
    rd(12'h000, d);
    chk(d == 32'(selM), "R2 index untouched", 64'(d), 64'(selM));
    rd(12'h010, d);
    chk(d == expWin(BASE + 4), "R2 window untouched", 64'(d), 64'(expWin(BASE + 4)));

    finishRun();
  end

endmodule